// File: doc/BRIEF.md
# AHB Slave to Avalon Memory-Mapped Bridge

This block lets one AHB master reach a set of memory-mapped Avalon slaves that share the same clock. It acts as an AHB slave. It latches each valid address phase and replays it on the Avalon side one cycle later. In that cycle the AHB write data is present, so the Avalon slave sees address, strobe, byte enables and write data together. Each access is a fundamental Avalon transfer: no pipelining, and read data is valid when wait-request falls.

Bursts of every kind are accepted. Each beat becomes an independent single Avalon access, and the burst type plays no part in the decision. The Avalon wait-request is returned, inverted, as the AHB ready output, so the master stalls exactly as long as the slave does. The response is always OKAY. Chip-select decoding sits in the fabric outside the bridge. For a lone slave, the bus ready input is simply the bridge's own ready output.

Top module: `ahb2av_bridge`

## Requirements
- R1: `hresp` is 2'b00 (OKAY) in every cycle, including during reset and during stalls.
- R2: `hreadyo` is high exactly when `av_waitrequest` is low.
- R3: An address phase with `hsel`, `hreadyi` and `htrans[1]` all high appears on the Avalon side in the next cycle. `av_address` equals that `haddr`. `av_write` is high if `hwrite` was 1, and `av_read` is high if it was 0.
- R4: While `av_write` is high, `av_writedata` equals the current `hwdata`.
- R5: A byte access (`hsize[1:0]`=0) at low address bits n gives `av_byteenable` = 1<<n.
- R6: A halfword access (`hsize[1:0]`=1) gives 4'b0011 when `haddr[1]`=0 and 4'b1100 when `haddr[1]`=1.
- R7: A word access (`hsize[1:0]`=2) gives 4'b1111 for any low address bits.
- R8: A cycle with `htrans` IDLE (0) or BUSY (1), with `hsel` low, or with `hreadyi` low starts no access. Both strobes are low in the next cycle.
- R9: While a strobe is high and `av_waitrequest` is high, the strobes, address and byte enables hold in the next cycle.
- R10: After an access completes (strobe high, `av_waitrequest` low), the strobes drop in the next cycle unless a new address phase was accepted in that completing cycle.
- R11: Beats of a burst given back to back (NONSEQ then SEQ, any `hburst`) produce one Avalon access per beat, in consecutive cycles, each with its own address.
- R12: `hrdata` equals `av_readdata`, so a read returns the slave data in the cycle `av_waitrequest` is low.
- R13: While `rst` is high (synchronous, active high), both strobes are low after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both sides |
| rst | input | 1 | Synchronous reset, active high |
| hsel | input | 1 | Slave select from the AHB decoder |
| haddr | input | ADDR_W | AHB address |
| htrans | input | 2 | Transfer type: 0 IDLE, 1 BUSY, 2 NONSEQ, 3 SEQ |
| hwrite | input | 1 | 1 for write, 0 for read |
| hsize | input | 3 | Transfer size; only bits 1:0 are used |
| hburst | input | 3 | Burst type; accepted and not used |
| hwdata | input | 32 | AHB write data (data phase) |
| hreadyi | input | 1 | Bus-level ready; an address phase counts only when high |
| hrdata | output | 32 | Read data to the master |
| hreadyo | output | 1 | Slave ready to the master |
| hresp | output | 2 | Transfer response, always OKAY |
| av_address | output | ADDR_W | Avalon address, delayed one cycle |
| av_read | output | 1 | Avalon read strobe |
| av_write | output | 1 | Avalon write strobe |
| av_writedata | output | 32 | Avalon write data |
| av_byteenable | output | 4 | Avalon byte lanes |
| av_readdata | input | 32 | Avalon read data |
| av_waitrequest | input | 1 | Avalon stall request |

## Verification
The only internal state is the latched access: a valid flag, its direction, its address and its lane mask. If any of these is wrong, it shows on the Avalon strobes, address or byte enables in the cycle right after the address phase. A stale valid flag shows as a strobe left high one cycle after a completion or after an IDLE, BUSY or deselected phase. A corrupted hold shows as a changed address or strobe in the cycle after the slave raises wait-request. The bench therefore checks every data-phase cycle and the cycle that follows it. It sweeps all sizes, offsets and directions with zero, one and two wait states.

// File: rtl/ahb2av_pkg.sv
package ahb2av_pkg;

    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;
    localparam int LANE_W = $clog2(BE_W);

    typedef enum logic [1:0] {
        HT_IDLE   = 2'd0,
        HT_BUSY   = 2'd1,
        HT_NONSEQ = 2'd2,
        HT_SEQ    = 2'd3
    } htrans_e;

    typedef enum logic [1:0] {
        RESP_OKAY  = 2'd0,
        RESP_ERROR = 2'd1,
        RESP_RETRY = 2'd2,
        RESP_SPLIT = 2'd3
    } hresp_e;

    // Number of bytes covered by a size code, clamped to the bus width.
    function automatic logic [LANE_W:0] size_bytes(input logic [1:0] sz);
        if (int'(sz) >= LANE_W)
            return (LANE_W+1)'(BE_W);
        return (LANE_W+1)'(1) << sz;
    endfunction

    // An address phase is taken when the slave is selected, the bus is ready
    // and the transfer type is NONSEQ or SEQ.
    function automatic logic phase_valid(input logic sel, input logic rdy,
                                         input logic [1:0] tr);
        return sel && rdy && tr[1];
    endfunction

endpackage

// File: rtl/ahb2av_lane_decode.sv
module ahb2av_lane_decode
    import ahb2av_pkg::*;
(
    input  logic [1:0]        size_code,
    input  logic [LANE_W-1:0] lane_off,
    output logic [BE_W-1:0]   lane_mask
);

    logic [LANE_W:0]   nbytes;
    logic [LANE_W-1:0] base;
    logic [LANE_W:0]   limit;

    always_comb begin
        nbytes = size_bytes(size_code);
        base   = lane_off & ~LANE_W'(nbytes - (LANE_W+1)'(1));
        limit  = {1'b0, base} + nbytes;
    end

    for (genvar i = 0; i < BE_W; i++) begin : g_lane
        assign lane_mask[i] = ({1'b0, base} <= (LANE_W+1)'(i)) &&
                              ((LANE_W+1)'(i) < limit);
    end

endmodule

// File: rtl/ahb2av_phase_reg.sv
module ahb2av_phase_reg
    import ahb2av_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hsel,
    input  logic              hreadyi,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [1:0]        size_code,
    input  logic [ADDR_W-1:0] haddr,
    output logic              slot_valid,
    output logic              slot_wr,
    output logic [ADDR_W-1:0] slot_addr,
    output logic [BE_W-1:0]   slot_be
);

    logic            take;
    logic [BE_W-1:0] be_next;

    assign take = phase_valid(hsel, hreadyi, htrans);

    ahb2av_lane_decode u_lanes (
        .size_code (size_code),
        .lane_off  (haddr[LANE_W-1:0]),
        .lane_mask (be_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_valid <= 1'b0;
            slot_wr    <= 1'b0;
            slot_addr  <= '0;
            slot_be    <= '0;
        end else if (hreadyi) begin
            slot_valid <= take;
            if (take) begin
                slot_wr   <= hwrite;
                slot_addr <= haddr;
                slot_be   <= be_next;
            end
        end
    end

    // R7: a word-sized phase yields all lanes on the following cycle
    p_word_r7: assert property (@(posedge clk) disable iff (rst)
        (take && size_code == 2'd2) |=> (slot_be == '1));

endmodule

// File: rtl/ahb2av_bridge.sv
module ahb2av_bridge
    import ahb2av_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [2:0]        hsize,
    input  logic [2:0]        hburst,
    input  logic [DATA_W-1:0] hwdata,
    input  logic              hreadyi,
    output logic [DATA_W-1:0] hrdata,
    output logic              hreadyo,
    output logic [1:0]        hresp,
    output logic [ADDR_W-1:0] av_address,
    output logic              av_read,
    output logic              av_write,
    output logic [DATA_W-1:0] av_writedata,
    output logic [BE_W-1:0]   av_byteenable,
    input  logic [DATA_W-1:0] av_readdata,
    input  logic              av_waitrequest
);

    logic slot_valid;
    logic slot_wr;
    logic unused_ctrl;

    // Burst kind and the top size bit play no part in the conversion.
    assign unused_ctrl = ^{hburst, hsize[2]};

    ahb2av_phase_reg #(.ADDR_W(ADDR_W)) u_phase (
        .clk        (clk),
        .rst        (rst),
        .hsel       (hsel),
        .hreadyi    (hreadyi),
        .htrans     (htrans),
        .hwrite     (hwrite),
        .size_code  (hsize[1:0]),
        .haddr      (haddr),
        .slot_valid (slot_valid),
        .slot_wr    (slot_wr),
        .slot_addr  (av_address),
        .slot_be    (av_byteenable)
    );

    assign av_read      = slot_valid && !slot_wr;
    assign av_write     = slot_valid &&  slot_wr;
    assign av_writedata = hwdata;
    assign hrdata       = av_readdata;
    assign hreadyo      = !av_waitrequest;
    assign hresp        = RESP_OKAY;

    logic phase_ok;
    assign phase_ok = hsel && hreadyi && htrans[1];

    // R3: an accepted phase becomes a strobe on the next cycle
    p_capture_r3: assert property (@(posedge clk) disable iff (rst)
        phase_ok |=> (av_read || av_write));

    // R3: direction follows hwrite of the accepted phase
    p_dir_r3: assert property (@(posedge clk) disable iff (rst)
        (phase_ok && hwrite) |=> av_write);

    // R8: a ready cycle without a valid phase leaves the Avalon side quiet
    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (hreadyi && !phase_ok) |=> !(av_read || av_write));

    // R9: a stalled access holds its strobe, address and lanes
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        ((av_read || av_write) && av_waitrequest) |=>
        ($stable(av_read) && $stable(av_write) &&
         $stable(av_address) && $stable(av_byteenable)));

    // R10: a completed access with no new phase drops its strobe
    p_drop_r10: assert property (@(posedge clk) disable iff (rst)
        ((av_read || av_write) && !av_waitrequest && !phase_ok) |=>
        !(av_read || av_write));

endmodule

// File: tb/tb_ahb2av_bridge.sv
module tb_ahb2av_bridge;

    localparam int AW = 32;

    logic        clk = 1'b0;
    logic        rst;
    logic        hsel;
    logic [AW-1:0] haddr;
    logic [1:0]  htrans;
    logic        hwrite;
    logic [2:0]  hsize;
    logic [2:0]  hburst;
    logic [31:0] hwdata;
    logic        hreadyi;
    logic [31:0] hrdata;
    logic        hreadyo;
    logic [1:0]  hresp;
    logic [AW-1:0] av_address;
    logic        av_read;
    logic        av_write;
    logic [31:0] av_writedata;
    logic [3:0]  av_byteenable;
    logic [31:0] av_readdata;
    logic        av_waitrequest;
    logic        block_ready;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = !clk;

    assign hreadyi = block_ready ? 1'b0 : hreadyo;

    ahb2av_bridge #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .hsel(hsel), .haddr(haddr), .htrans(htrans),
        .hwrite(hwrite), .hsize(hsize), .hburst(hburst), .hwdata(hwdata),
        .hreadyi(hreadyi), .hrdata(hrdata), .hreadyo(hreadyo), .hresp(hresp),
        .av_address(av_address), .av_read(av_read), .av_write(av_write),
        .av_writedata(av_writedata), .av_byteenable(av_byteenable),
        .av_readdata(av_readdata), .av_waitrequest(av_waitrequest)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_be(input int sz, input int off);
        int nb;
        int base;
        nb = 1 << sz;
        if (nb >= 4) return 4'hF;
        base = off - (off % nb);
        return 4'(((1 << nb) - 1) << base);
    endfunction

    task automatic idle_bus();
        hsel = 0; htrans = 2'd0; hwrite = 0; hsize = 3'd0;
        hburst = 3'd0; haddr = '0;
    endtask

    // One single transfer with nwait wait states.
    task automatic single(input int sz, input int off, input bit wr,
                          input int nwait, input int idx);
        logic [31:0] a;
        logic [31:0] wd;
        logic [31:0] rd;
        logic [3:0]  be;
        a  = 32'h4000_0000 + 32'(idx * 16) + 32'(off);
        wd = 32'hA500_0000 ^ 32'(idx * 32'h0101_0101);
        rd = 32'h5A00_0000 + 32'(idx << 8);
        be = exp_be(sz, off);
        @(negedge clk);
        hsel = 1; htrans = 2'd2; hwrite = wr; hsize = 3'(sz);
        haddr = a; hburst = 3'd0; av_waitrequest = 0;
        for (int k = 0; k <= nwait; k++) begin
            @(negedge clk);
            if (k == 0) begin
                idle_bus();
                hwdata = wd;
            end
            av_waitrequest = (k < nwait);
            av_readdata = rd + 32'(k);
            #1;
            chk(av_write == wr && av_read == !wr, "R3 strobe",
                {30'd0, av_read, av_write}, {30'd0, !wr, wr});
            chk(av_address == a, "R3/R9 address", av_address, a);
            if (sz == 0) chk(av_byteenable == be, "R5 byte lanes",
                             32'(av_byteenable), 32'(be));
            else if (sz == 1) chk(av_byteenable == be, "R6 halfword lanes",
                                  32'(av_byteenable), 32'(be));
            else chk(av_byteenable == be, "R7 word lanes",
                     32'(av_byteenable), 32'(be));
            chk(hreadyo == (k == nwait), "R2 ready", 32'(hreadyo),
                32'(k == nwait));
            chk(hresp == 2'b00, "R1 response", 32'(hresp), 0);
            if (wr) chk(av_writedata == wd, "R4 write data", av_writedata, wd);
            if (!wr && k == nwait)
                chk(hrdata == rd + 32'(k), "R12 read data", hrdata, rd + 32'(k));
        end
        @(negedge clk);
        av_waitrequest = 0;
        #1;
        chk(!av_read && !av_write, "R10 strobe drop",
            {30'd0, av_read, av_write}, 0);
    endtask

    // Address phases back to back; act[i]=1 means a strobe is expected
    // in the cycle after phase i.
    task automatic burst(input bit wr, input logic [2:0] kind);
        logic [1:0]  tr  [6] = '{2'd2, 2'd3, 2'd1, 2'd3, 2'd3, 2'd0};
        logic [31:0] ad  [6];
        bit          act [6] = '{1, 1, 0, 1, 1, 0};
        logic [31:0] base;
        base = 32'h2000_0100;
        ad = '{base, base + 4, base + 8, base + 8, base + 12, 32'd0};
        for (int i = 0; i <= 6; i++) begin
            @(negedge clk);
            av_waitrequest = 0;
            hwdata = 32'hC0DE_0000 + 32'(i);
            if (i < 6) begin
                hsel = (tr[i] != 2'd0); htrans = tr[i]; haddr = ad[i];
                hwrite = wr; hsize = 3'd2; hburst = kind;
            end else begin
                idle_bus();
            end
            #1;
            if (i > 0) begin
                if (act[i-1]) begin
                    chk((wr ? av_write : av_read) == 1'b1, "R11 beat strobe",
                        {30'd0, av_read, av_write}, {30'd0, !wr, wr});
                    chk(av_address == ad[i-1], "R11 beat address",
                        av_address, ad[i-1]);
                end else begin
                    chk(!av_read && !av_write, "R8 busy/idle no access",
                        {30'd0, av_read, av_write}, 0);
                end
            end
        end
    endtask

    initial begin
        idle_bus();
        hwdata = '0; av_readdata = '0; av_waitrequest = 0; block_ready = 0;
        rst = 1;
        @(negedge clk);
        hsel = 1; htrans = 2'd2; hwrite = 1;
        @(negedge clk);
        #1;
        chk(!av_read && !av_write, "R13 reset strobes",
            {30'd0, av_read, av_write}, 0);
        chk(hresp == 2'b00, "R1 reset response", 32'(hresp), 0);
        idle_bus();
        @(negedge clk);
        rst = 0;

        begin
            int idx = 0;
            for (int sz = 0; sz < 3; sz++)
                for (int off = 0; off < 4; off++)
                    for (int wr = 0; wr < 2; wr++) begin
                        single(sz, off, wr[0], (sz + off + wr) % 3, idx);
                        idx++;
                    end
        end

        burst(1'b1, 3'd3);
        burst(1'b0, 3'd2);
        burst(1'b1, 3'd1);

        // R8: deselected phase
        @(negedge clk);
        hsel = 0; htrans = 2'd2; hwrite = 1; haddr = 32'h10;
        @(negedge clk);
        idle_bus();
        #1;
        chk(!av_read && !av_write, "R8 hsel low",
            {30'd0, av_read, av_write}, 0);

        // R8: bus ready low during the phase
        @(negedge clk);
        block_ready = 1;
        hsel = 1; htrans = 2'd2; hwrite = 0; haddr = 32'h20;
        @(negedge clk);
        block_ready = 0;
        idle_bus();
        #1;
        chk(!av_read && !av_write, "R8 hreadyi low",
            {30'd0, av_read, av_write}, 0);

        // R2 outside any access
        av_waitrequest = 1;
        #1;
        chk(hreadyo == 1'b0, "R2 idle ready", 32'(hreadyo), 0);
        av_waitrequest = 0;
        #1;
        chk(hreadyo == 1'b1, "R2 idle ready", 32'(hreadyo), 1);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(5 * 150000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule